// File: doc/BRIEF.md
# Pulse-Pause Bit Decoder and Framer

This block sits on the receive side of a contactless link, where the reader talks to the card. It takes the digitized carrier-envelope level and passes it through a synchronizer. It then times the spacing between consecutive rising edges, counting in ticks of the system clock divided by a prescale factor. Each spacing is sorted into one of three cases: a 1 bit, a 0 bit, or an out-of-window interval. The bits are packed into a frame, with the first bit received in the least significant position.

A frame ends in one of two ways. The first is an out-of-window interval that arrives while a frame is in progress. The second is silence that lasts past the longest valid interval. At frame end the block presents the bit count and the data for exactly one clock cycle, and then starts the next frame empty. The running interval counter is also driven out, so that a reply generator can time its answer from the last rising edge. After a long idle the counter stops at a ceiling value and waits for the next edge.

Top module: `pulse_pause_rx`

## Requirements
- R1: The envelope input is synchronized through two flops. Each rising edge of the synchronized level restarts the interval counter from zero. The count held just before the restart is the interval that gets classified, and `interval_count` reads at most 3 within a few cycles after an edge.
- R2: The counter advances by exactly one for every TICK_DIV system clocks. The prescaler phase also restarts on each rising edge.
- R3: An interval of 131 to 169 ticks, inclusive, decodes as a 1 bit and opens or continues a frame.
- R4: An interval of 71 to 109 ticks, inclusive, decodes as a 0 bit and opens or continues a frame.
- R5: While a frame is open, any interval outside both windows (for example 70, 110, 130 or 170 ticks) closes the frame and emits it.
- R6: While no frame is open, an out-of-window interval does nothing. It produces no strobe and leaves no bits behind.
- R7: While a frame is open, the frame closes and is emitted once the counter reaches 170 ticks without a new rising edge.
- R8: Bit k of the frame, counting from 0, lands in `frame_data[k]`. Every `frame_data` bit at or above `frame_bits` is zero.
- R9: A frame holds at most 15 bits. Any bits received beyond the 15th are discarded, and `frame_bits` never exceeds 15.
- R10: When no edge arrives, the counter stops at 3000 ticks and stays there until the next rising edge.
- R11: `frame_valid` is high for exactly one cycle per frame, with `frame_bits` and `frame_data` valid in that cycle. The next frame then starts with count and data at zero.
- R12: A rising edge can arrive in the same cycle that the counter reaches the 170-tick silence limit. In that case the open frame is emitted exactly once, and the edge still restarts the interval for the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| env_in | input | 1 | Asynchronous digitized carrier envelope |
| frame_valid | output | 1 | One-cycle strobe marking a completed frame |
| frame_bits | output | 4 | Number of bits in the completed frame |
| frame_data | output | 15 | Frame bits, first received in bit 0 |
| interval_count | output | 12 | Ticks elapsed since the last rising edge, saturating at 3000 |

## Verification
Two events can fall in the same cycle: a rising edge whose interval is out of window, and the silence timeout, since both fire when the count reaches 170. The bench spaces an edge exactly 170 ticks after the previous one inside an open frame, so that both triggers arrive in the same cycle. It then counts strobes over the following window. The result is judged correct only if the frame is emitted once with its contents intact, and the next interval of 150 ticks then opens a new one-bit frame.

// File: rtl/ppr_pkg.sv
package ppr_pkg;

    // Classification of one measured interval
    typedef enum logic [1:0] {
        SYM_ZERO = 2'd0,
        SYM_ONE  = 2'd1,
        SYM_BAD  = 2'd2
    } sym_e;

endpackage

// File: rtl/ppr_sync.sv
module ppr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);

    logic [STAGES-1:0] sync_d, sync_q;
    logic              prev_d, prev_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], din};
        prev_d = sync_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    // Edge seen on the synchronized level against its one-cycle delay
    assign rise = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/ppr_tick.sv
module ppr_tick #(
    parameter int DIV = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);

    localparam int PRE_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PRE_W-1:0] LAST = PRE_W'(DIV - 1);

    logic [PRE_W-1:0] pre_d, pre_q;

    always_comb begin
        if (restart) begin
            pre_d = '0;
        end else if (pre_q == LAST) begin
            pre_d = '0;
        end else begin
            pre_d = pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    assign tick = (pre_q == LAST) && !restart;

endmodule

// File: rtl/ppr_interval.sv
module ppr_interval #(
    parameter int HALT  = 3000,
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             tick,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CEIL = CNT_W'(HALT);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart) begin
            cnt_d = '0;
        end else if (tick && (cnt_q < CEIL)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

endmodule

// File: rtl/ppr_classify.sv
module ppr_classify
    import ppr_pkg::*;
#(
    parameter int CNT_W    = 12,
    parameter int ONE_NOM  = 150,
    parameter int ZERO_NOM = 90,
    parameter int TOL      = 20
) (
    input  logic [CNT_W-1:0] count,
    output sym_e             sym
);

    // Open windows: strictly greater than LO, strictly less than HI
    localparam logic [CNT_W-1:0] ONE_LO  = CNT_W'(ONE_NOM - TOL);
    localparam logic [CNT_W-1:0] ONE_HI  = CNT_W'(ONE_NOM + TOL);
    localparam logic [CNT_W-1:0] ZERO_LO = CNT_W'(ZERO_NOM - TOL);
    localparam logic [CNT_W-1:0] ZERO_HI = CNT_W'(ZERO_NOM + TOL);

    logic in_one, in_zero;

    always_comb begin
        in_one  = (count > ONE_LO)  && (count < ONE_HI);
        in_zero = (count > ZERO_LO) && (count < ZERO_HI);
        if (in_one)       sym = SYM_ONE;
        else if (in_zero) sym = SYM_ZERO;
        else              sym = SYM_BAD;
    end

endmodule

// File: rtl/pulse_pause_rx.sv
module pulse_pause_rx
    import ppr_pkg::*;
#(
    parameter int TICK_DIV    = 32,
    parameter int ONE_NOM     = 150,
    parameter int ZERO_NOM    = 90,
    parameter int TOL         = 20,
    parameter int HALT_TICKS  = 3000,
    parameter int MAX_BITS    = 15,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(HALT_TICKS + 1),
    localparam int BITS_W     = $clog2(MAX_BITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              env_in,
    output logic              frame_valid,
    output logic [BITS_W-1:0] frame_bits,
    output logic [MAX_BITS-1:0] frame_data,
    output logic [CNT_W-1:0]  interval_count
);

    localparam logic [CNT_W-1:0]  END_CNT  = CNT_W'(ONE_NOM + TOL);
    localparam logic [BITS_W-1:0] BIT_CAP  = BITS_W'(MAX_BITS);

    typedef struct packed {
        logic                active;
        logic [BITS_W-1:0]   nbits;
        logic [MAX_BITS-1:0] data;
        logic                out_valid;
        logic [BITS_W-1:0]   out_bits;
        logic [MAX_BITS-1:0] out_data;
    } fr_t;

    logic             edge_rise;
    logic             tick;
    logic [CNT_W-1:0] count;
    sym_e             sym;
    fr_t              fr_d, fr_q;
    logic             end_frame;
    logic             bit_val;

    ppr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (env_in),
        .rise (edge_rise)
    );

    ppr_tick #(.DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(edge_rise),
        .tick   (tick)
    );

    ppr_interval #(.HALT(HALT_TICKS), .CNT_W(CNT_W)) u_interval (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(edge_rise),
        .tick   (tick),
        .count  (count)
    );

    ppr_classify #(
        .CNT_W   (CNT_W),
        .ONE_NOM (ONE_NOM),
        .ZERO_NOM(ZERO_NOM),
        .TOL     (TOL)
    ) u_classify (
        .count(count),
        .sym  (sym)
    );

    always_comb begin
        fr_d           = fr_q;
        fr_d.out_valid = 1'b0;
        end_frame      = 1'b0;
        bit_val        = (sym == SYM_ONE);

        if (edge_rise) begin
            if (sym == SYM_BAD) begin
                // Out-of-window edge closes an open frame, ignored when idle
                end_frame = fr_q.active;
            end else begin
                fr_d.active = 1'b1;
                if (fr_q.nbits < BIT_CAP) begin
                    fr_d.data  = fr_q.data | (MAX_BITS'(bit_val) << fr_q.nbits);
                    fr_d.nbits = fr_q.nbits + 1'b1;
                end
            end
        end else if (fr_q.active && (count >= END_CNT)) begin
            // Silence past the longest valid interval
            end_frame = 1'b1;
        end

        if (end_frame) begin
            fr_d.out_valid = 1'b1;
            fr_d.out_bits  = fr_q.nbits;
            fr_d.out_data  = fr_q.data;
            fr_d.active    = 1'b0;
            fr_d.nbits     = '0;
            fr_d.data      = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fr_q <= '0;
        else        fr_q <= fr_d;
    end

    assign frame_valid    = fr_q.out_valid;
    assign frame_bits     = fr_q.out_bits;
    assign frame_data     = fr_q.out_data;
    assign interval_count = count;

endmodule

// File: rtl/ppr_checker.sv
module ppr_checker #(
    parameter int CNT_W    = 12,
    parameter int BITS_W   = 4,
    parameter int MAX_BITS = 15,
    parameter int HALT     = 3000
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rise,
    input logic [CNT_W-1:0]    interval_count,
    input logic                frame_valid,
    input logic [BITS_W-1:0]   frame_bits,
    input logic [MAX_BITS-1:0] frame_data
);

    localparam logic [CNT_W-1:0]  CEIL = CNT_W'(HALT);
    localparam logic [BITS_W-1:0] CAP  = BITS_W'(MAX_BITS);

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (interval_count == '0)); // R1

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> ((interval_count == $past(interval_count)) ||
                   (interval_count == CNT_W'($past(interval_count) + 1'b1)))); // R2

    AST_HALT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        interval_count <= CEIL); // R10

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (interval_count == CEIL && !rise) |=> (interval_count == CEIL)); // R10

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid); // R11

    AST_FRAME_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> (frame_bits != '0 && frame_bits <= CAP)); // R9

    AST_DATA_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> ((frame_data >> frame_bits) == '0)); // R8

endmodule

bind pulse_pause_rx ppr_checker #(
    .CNT_W   (CNT_W),
    .BITS_W  (BITS_W),
    .MAX_BITS(MAX_BITS),
    .HALT    (HALT_TICKS)
) u_ppr_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .rise          (edge_rise),
    .interval_count(interval_count),
    .frame_valid   (frame_valid),
    .frame_bits    (frame_bits),
    .frame_data    (frame_data)
);

// File: tb/pulse_pause_rx_bench.sv
module pulse_pause_rx_bench;

    localparam int DIV  = 2;
    localparam int NVEC = 7;

    // {sent bits[4:0], pattern[15:0], expected count[3:0], expected data[14:0]}
    localparam logic [39:0] VEC [NVEC] = '{
        {5'd1,  16'h0001, 4'd1,  15'h0001},
        {5'd2,  16'h0002, 4'd2,  15'h0002},
        {5'd7,  16'h0055, 4'd7,  15'h0055},
        {5'd6,  16'h003B, 4'd6,  15'h003B},
        {5'd15, 16'h4A5C, 4'd15, 15'h4A5C},
        {5'd16, 16'hFFFF, 4'd15, 15'h7FFF},
        {5'd5,  16'h0000, 4'd5,  15'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        env_in = 1'b0;
    logic        frame_valid;
    logic [3:0]  frame_bits;
    logic [14:0] frame_data;
    logic [11:0] interval_count;

    int checks = 0;
    int errs = 0;
    int strobes = 0;
    logic [3:0]  got_bits = '0;
    logic [14:0] got_data = '0;

    always #10 clk = ~clk;

    pulse_pause_rx #(.TICK_DIV(DIV)) u_pulse_pause_rx (
        .clk           (clk),
        .rst_n         (rst_n),
        .env_in        (env_in),
        .frame_valid   (frame_valid),
        .frame_bits    (frame_bits),
        .frame_data    (frame_data),
        .interval_count(interval_count)
    );

    always @(negedge clk) begin
        if (frame_valid) begin
            strobes  <= strobes + 1;
            got_bits <= frame_bits;
            got_data <= frame_data;
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: got=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    task automatic edge_pulse();
        env_in = 1'b1;
        repeat (2) @(negedge clk);
        env_in = 1'b0;
    endtask

    // Next rising edge lands k ticks after the previous one
    task automatic after(input int k);
        repeat (k * DIV + 1 - 2) @(negedge clk);
        edge_pulse();
    endtask

    task automatic idle(input int cyc);
        repeat (cyc) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: got=hung expected=finished");
        report();
    end

    initial begin
        int s0;
        int c0;
        @(negedge clk);
        @(negedge clk);
        check("R11 reset valid", frame_valid, 0);
        check("R11 reset bits", frame_bits, 0);
        check("R11 reset data", frame_data, 0);
        check("R1 reset count", interval_count, 0);
        rst_n = 1'b1;
        idle(10);

        // R6: out-of-window intervals while idle are ignored
        s0 = strobes;
        edge_pulse();
        after(50);
        after(200);
        idle(200 * DIV);
        check("R6 idle strobes", strobes - s0, 0);

        // Table-driven frames: R3 R4 R7 R8 R9 R11
        for (int v = 0; v < NVEC; v++) begin
            logic [4:0]  n;
            logic [15:0] pat;
            n   = VEC[v][39:35];
            pat = VEC[v][34:19];
            s0  = strobes;
            edge_pulse();
            for (int i = 0; i < int'(n); i++) after(pat[i] ? 150 : 90);
            idle(200 * DIV);
            check("R7 R11 frame strobe count", strobes - s0, 1);
            check("R9 frame bits", got_bits, VEC[v][18:15]);
            check("R8 frame data", got_data, VEC[v][14:0]);
        end

        // R3 R4 window edges, then R5 close on 110
        s0 = strobes;
        edge_pulse();
        after(131); after(169); after(71); after(109); after(110);
        idle(200 * DIV);
        check("R5 window strobes", strobes - s0, 1);
        check("R3 R4 window bits", got_bits, 4);
        check("R3 R4 window data", got_data, 15'h0003);

        // R5 close on 130 and on 70
        s0 = strobes;
        edge_pulse();
        after(150); after(130);
        idle(200 * DIV);
        check("R5 close130 strobes", strobes - s0, 1);
        check("R5 close130 bits", got_bits, 1);
        check("R5 close130 data", got_data, 1);
        s0 = strobes;
        edge_pulse();
        after(90); after(70);
        idle(200 * DIV);
        check("R5 close70 strobes", strobes - s0, 1);
        check("R5 close70 bits", got_bits, 1);
        check("R5 close70 data", got_data, 0);

        // R12: edge arrives exactly at the 170-tick silence limit
        s0 = strobes;
        edge_pulse();
        after(150); after(90); after(170);
        idle(20);
        check("R12 single strobe", strobes - s0, 1);
        check("R12 bits", got_bits, 2);
        check("R12 data", got_data, 1);
        after(150);
        idle(200 * DIV);
        check("R12 next frame strobes", strobes - s0, 2);
        check("R12 next frame bits", got_bits, 1);
        check("R12 next frame data", got_data, 1);

        // R10: ceiling after long idle
        idle(3100 * DIV);
        check("R10 halted", interval_count, 3000);
        idle(10 * DIV);
        check("R10 still halted", interval_count, 3000);

        // R1: edge restarts the counter
        s0 = strobes;
        edge_pulse();
        idle(4);
        check("R1 restart", interval_count <= 3, 1);

        // R2: one step per DIV clocks
        idle(5 * DIV);
        c0 = interval_count;
        idle(10 * DIV);
        check("R2 rate", interval_count - c0, 10);
        idle(200 * DIV);
        check("R6 halt-edge ignored", strobes - s0, 0);

        report();
    end

endmodule